// File: doc/BRIEF.md
# Asynchronous Serial Frame Decoder

This block watches one asynchronous serial line and turns each frame into a stream of typed events. Bit timing comes from a clock-cycles-per-bit divisor. After the line is synchronised, a high-to-low transition arms the decoder. It then samples the start bit halfway through, and every following data, parity and stop bit in the middle of its own period.

The frame shape is set at run time:
- a data width of 5 to 9 bits
- least- or most-significant-bit-first order
- one of five parity settings
- one of four stop lengths
- two independent inversions: one inverts the whole line, the other inverts only data and parity

All settings and the divisor are captured at the arming edge and held for the whole frame. Each element of the frame leaves as a one-cycle pulse on a valid/type/data output, in frame order. A monitor or a downstream parser can rebuild the frame from these pulses, including glitches, framing faults and parity mismatches.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset no event is emitted until the line has been seen idle and then shows a falling edge (idle is high after any full-line inversion). While idle, the bit timer never fires.
- R2: If the start bit reads high at its mid-bit point (half the divisor after the edge), one invalid-start event (type 4, data 1) is emitted and the decoder returns to idle without decoding data.
- R3: A valid frame emits a start event (type 0, data 0), then one data event (type 1). The data event carries the received word right-aligned in bits [width-1:0] with upper bits zero. Width codes below 5 act as 5 and above 9 act as 9. With `msb_first_i`=0 the first data bit on the line is bit 0; with 1 it is bit width-1.
- R4: Parity codes 1 (odd) and 2 (even) make the data ones plus the parity bit total an odd or an even count. Code 0 means no parity bit. The received parity bit is reported as a parity event (type 2, data = the bit).
- R5: Parity code 3 expects the parity bit to be 1, and code 4 expects it to be 0.
- R6: When the received parity bit differs from the expected one, a parity-error event (type 6) follows the parity event in the next cycle. Its data is bit 1 = expected and bit 0 = received.
- R7: Stop code 0 is one stop bit and code 1 is two. Code 2 is one stop bit lasting 1.5 periods and code 3 is one lasting 0.5 periods. Each stop bit is sampled at the middle of its own length and reported as a stop event (type 3, data 1). After the last stop sample the decoder is ready at once for the next start edge, so frames with a half-period stop can follow each other without a gap.
- R8: A low level at a stop-bit sample emits an invalid-stop event (type 5, data 0) and returns the decoder to idle.
- R9: With `inv_line_i`=1 the whole line is complemented, so idle and stop are low and the start bit is high.
- R10: With `inv_data_i`=1 only the data and parity bits are complemented before decoding. Reported data and parity values are the complemented ones; start and stop keep normal polarity.
- R11: Width, parity, stop, order, both inversions and the divisor are captured at the arming edge. Changing the inputs during a frame has no effect on that frame.
- R12: Each event is a single-cycle pulse with a type code from 0 to 6. Events leave in frame order. The divisor must be at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Asynchronous serial line |
| div_i | input | DIV_W | Clock cycles per bit (at least 4) |
| width_i | input | 4 | Data bits per frame, 5 to 9 |
| parity_i | input | 3 | 0 none, 1 odd, 2 even, 3 mark, 4 space |
| stop_i | input | 2 | 0 one, 1 two, 2 one-and-a-half, 3 half |
| msb_first_i | input | 1 | Data order: 1 = most significant bit first |
| inv_line_i | input | 1 | Complement the whole line |
| inv_data_i | input | 1 | Complement only data and parity bits |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_type_o | output | 3 | Event type code |
| ev_data_o | output | 9 | Event payload |

## Verification
The bench builds the decoder with its defaults, DIV_W of 16 and a two-stage synchroniser, and drives a divisor of 20. With that divisor, the half and quarter bit points fall on whole cycles (10 and 5). The half-period and one-and-a-half-period stop lengths are therefore driven exactly, and a frame can start right after a half-period stop with no idle gap. The 16-bit divisor field would also allow very slow lines, but the bench keeps every frame to a few hundred cycles so that all parity, stop, order and inversion combinations fit in one run.

// File: rtl/rx_pkg.sv
// Shared encodings for the serial frame decoder.
// Assumes codes are stable: the event type values are decoded by consumers.
package rx_pkg;

    typedef enum logic [2:0] {
        EV_START     = 3'd0,
        EV_DATA      = 3'd1,
        EV_PARITY    = 3'd2,
        EV_STOP      = 3'd3,
        EV_BAD_START = 3'd4,
        EV_BAD_STOP  = 3'd5,
        EV_PAR_ERR   = 3'd6
    } ev_kind_e;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_TWO      = 2'd1,
        STOP_ONE_HALF = 2'd2,
        STOP_HALF     = 2'd3
    } stop_len_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP  = 3'd4
    } rx_state_e;

    localparam int WORD_W  = 9;
    localparam int MIN_W   = 5;

endpackage

// File: rtl/rx_line_cond.sv
// Line conditioner: synchronises the raw serial input through SYNC_STAGES
// flops, applies whole-line inversion, and flags a high-to-low transition
// of the normalised line. Assumes invert_i only changes while the decoder idles.
module rx_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic invert_i,
    output logic ln_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain; resets to the raw idle level.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign ln_o = sync_q[SYNC_STAGES-1] ^ invert_i;

    // Previous normalised level; resets low so no edge fires before idle is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= ln_o;
    end

    assign fall_o = prev_q & ~ln_o;

endmodule

// File: rtl/rx_bit_timer.sv
// Bit timer: a down counter reloaded by the frame controller; tick marks the
// end of each loaded interval. Assumes reload_val_i is at least 1.
module rx_bit_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             halt_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Count down the loaded interval while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (reload_i) begin
            cnt_q <= reload_val_i - 1'b1;
            run_q <= 1'b1;
        end else if (halt_i) begin
            run_q <= 1'b0;
        end else if (run_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_q && (cnt_q == '0);

    // R7: every interval handed to the timer is non-empty
    p_reload_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |-> reload_val_i != '0);

endmodule

// File: rtl/rx_frame_ctl.sv
// Frame controller: captures the configuration at the arming edge, walks
// start/data/parity/stop, and emits one registered event per frame element.
// Assumes the divisor is at least 4 so a parity-error event never meets a tick.
module rx_frame_ctl
    import rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ln_i,
    input  logic             fall_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [3:0]       width_i,
    input  logic [2:0]       parity_i,
    input  logic [1:0]       stop_i,
    input  logic             msb_first_i,
    input  logic             inv_line_i,
    input  logic             inv_data_i,
    output logic             inv_line_act_o,
    output logic             reload_o,
    output logic [DIV_W:0]   reload_val_o,
    output logic             halt_o,
    output logic             ev_valid_o,
    output logic [2:0]       ev_type_o,
    output logic [8:0]       ev_data_o
);

    rx_state_e         st_q, st_n;
    logic [DIV_W-1:0]  div_q;
    logic [3:0]        wid_q;
    par_mode_e         par_q;
    stop_len_e         stp_q;
    logic              msb_q, invl_q, invd_q;
    logic [3:0]        idx_q, idx_n;
    logic [WORD_W-1:0] word_q, word_n;
    logic              stop2_q, stop2_n;
    logic              perr_q, perr_n;
    logic [1:0]        perr_d_q, perr_d_n;
    logic              ev_v_n;
    ev_kind_e          ev_t_n;
    logic [8:0]        ev_d_n;

    logic [3:0]        wid_in;
    logic [DIV_W:0]    full_iv, qtr_iv, stop_iv;
    logic              dbit, exp_par;
    logic [3:0]        pos;

    // Clamp the requested width to the legal range.
    always_comb begin
        if (width_i < 4'(MIN_W))       wid_in = 4'(MIN_W);
        else if (width_i > 4'(WORD_W)) wid_in = 4'(WORD_W);
        else                           wid_in = width_i;
    end

    assign inv_line_act_o = (st_q == S_IDLE) ? inv_line_i : invl_q;
    assign dbit           = ln_i ^ invd_q;
    assign pos            = msb_q ? (wid_q - 4'd1 - idx_q) : idx_q;

    // Interval to the first stop sample, scaled by the stop length.
    always_comb begin
        full_iv = {1'b0, div_q};
        qtr_iv  = {3'b000, div_q[DIV_W-1:2]};
        case (stp_q)
            STOP_ONE_HALF: stop_iv = full_iv + qtr_iv;
            STOP_HALF:     stop_iv = full_iv - qtr_iv;
            default:       stop_iv = full_iv;
        endcase
    end

    // Expected parity bit from the received word.
    always_comb begin
        case (par_q)
            PAR_ODD:  exp_par = ~(^word_q);
            PAR_EVEN: exp_par = ^word_q;
            PAR_MARK: exp_par = 1'b1;
            default:  exp_par = 1'b0;
        endcase
    end

    // Next-state, timer control and event selection.
    always_comb begin
        st_n         = st_q;
        idx_n        = idx_q;
        word_n       = word_q;
        stop2_n      = stop2_q;
        perr_n       = perr_q;
        perr_d_n     = perr_d_q;
        reload_o     = 1'b0;
        reload_val_o = full_iv;
        halt_o       = 1'b0;
        ev_v_n       = 1'b0;
        ev_t_n       = EV_START;
        ev_d_n       = '0;
        case (st_q)
            S_IDLE: if (fall_i) begin
                reload_o     = 1'b1;
                reload_val_o = {2'b00, div_i[DIV_W-1:1]};
                st_n         = S_START;
            end
            S_START: if (tick_i) begin
                ev_v_n = 1'b1;
                if (!ln_i) begin
                    ev_t_n   = EV_START;
                    reload_o = 1'b1;
                    idx_n    = '0;
                    word_n   = '0;
                    stop2_n  = 1'b0;
                    st_n     = S_DATA;
                end else begin
                    ev_t_n = EV_BAD_START;
                    ev_d_n = 9'd1;
                    halt_o = 1'b1;
                    st_n   = S_IDLE;
                end
            end
            S_DATA: if (tick_i) begin
                word_n[pos] = dbit;
                reload_o    = 1'b1;
                if (idx_q == wid_q - 4'd1) begin
                    ev_v_n = 1'b1;
                    ev_t_n = EV_DATA;
                    ev_d_n = word_n;
                    if (par_q == PAR_NONE) begin
                        reload_val_o = stop_iv;
                        st_n         = S_STOP;
                    end else begin
                        st_n = S_PAR;
                    end
                end else begin
                    idx_n = idx_q + 4'd1;
                end
            end
            S_PAR: if (tick_i) begin
                ev_v_n       = 1'b1;
                ev_t_n       = EV_PARITY;
                ev_d_n       = {8'd0, dbit};
                perr_n       = (dbit != exp_par);
                perr_d_n     = {exp_par, dbit};
                reload_o     = 1'b1;
                reload_val_o = stop_iv;
                st_n         = S_STOP;
            end
            S_STOP: begin
                if (perr_q) begin
                    ev_v_n = 1'b1;
                    ev_t_n = EV_PAR_ERR;
                    ev_d_n = {7'd0, perr_d_q};
                    perr_n = 1'b0;
                end else if (tick_i) begin
                    ev_v_n = 1'b1;
                    if (ln_i) begin
                        ev_t_n = EV_STOP;
                        ev_d_n = 9'd1;
                        if (stp_q == STOP_TWO && !stop2_q) begin
                            stop2_n  = 1'b1;
                            reload_o = 1'b1;
                        end else begin
                            halt_o = 1'b1;
                            st_n   = S_IDLE;
                        end
                    end else begin
                        ev_t_n = EV_BAD_STOP;
                        halt_o = 1'b1;
                        st_n   = S_IDLE;
                    end
                end
            end
            default: begin
                halt_o = 1'b1;
                st_n   = S_IDLE;
            end
        endcase
    end

    // State, frame registers and event output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= S_IDLE;
            idx_q      <= '0;
            word_q     <= '0;
            stop2_q    <= 1'b0;
            perr_q     <= 1'b0;
            perr_d_q   <= '0;
            ev_valid_o <= 1'b0;
            ev_type_o  <= '0;
            ev_data_o  <= '0;
        end else begin
            st_q       <= st_n;
            idx_q      <= idx_n;
            word_q     <= word_n;
            stop2_q    <= stop2_n;
            perr_q     <= perr_n;
            perr_d_q   <= perr_d_n;
            ev_valid_o <= ev_v_n;
            ev_type_o  <= ev_t_n;
            ev_data_o  <= ev_d_n;
        end
    end

    // Configuration capture at the arming edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            wid_q  <= 4'(MIN_W);
            par_q  <= PAR_NONE;
            stp_q  <= STOP_ONE;
            msb_q  <= 1'b0;
            invl_q <= 1'b0;
            invd_q <= 1'b0;
        end else if (st_q == S_IDLE && fall_i) begin
            div_q  <= div_i;
            wid_q  <= wid_in;
            par_q  <= par_mode_e'(parity_i);
            stp_q  <= stop_len_e'(stop_i);
            msb_q  <= msb_first_i;
            invl_q <= inv_line_i;
            invd_q <= inv_data_i;
        end
    end

    // R1: the bit timer never fires while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_IDLE |-> !tick_i);

    // R3: a data event never carries bits above the captured width
    p_data_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && ev_type_o == EV_DATA) |-> ((ev_data_o >> wid_q) == '0));

    // R6: a parity-error event directly follows a parity event
    p_perr_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && ev_type_o == EV_PAR_ERR) |->
            $past(ev_valid_o && ev_type_o == EV_PARITY));

    // R11: captured configuration holds while a frame is in progress
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE && $past(st_q) != S_IDLE) |->
            ($stable(wid_q) && $stable(par_q) && $stable(msb_q) && $stable(div_q)));

    // R12: event types stay in the legal range
    p_type_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> ev_type_o != 3'd7);

    // R12: a start event is a single-cycle pulse
    p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && ev_type_o == EV_START) |=> !ev_valid_o);

endmodule

// File: rtl/serial_frame_rx.sv
// Configurable asynchronous serial frame decoder top level: joins the line
// conditioner, the bit timer and the frame controller. Assumes div_i >= 4.
module serial_frame_rx #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [3:0]       width_i,
    input  logic [2:0]       parity_i,
    input  logic [1:0]       stop_i,
    input  logic             msb_first_i,
    input  logic             inv_line_i,
    input  logic             inv_data_i,
    output logic             ev_valid_o,
    output logic [2:0]       ev_type_o,
    output logic [8:0]       ev_data_o
);

    localparam int CNT_W = DIV_W + 1;

    logic             ln, fall, tick, inv_act, reload, halt;
    logic [CNT_W-1:0] reload_val;

    rx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) line_i0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .invert_i (inv_act),
        .ln_o     (ln),
        .fall_o   (fall)
    );

    rx_bit_timer #(.CNT_W(CNT_W)) timer_i0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_i     (reload),
        .reload_val_i (reload_val),
        .halt_i       (halt),
        .tick_o       (tick)
    );

    rx_frame_ctl #(.DIV_W(DIV_W)) ctl_i0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .ln_i           (ln),
        .fall_i         (fall),
        .tick_i         (tick),
        .div_i          (div_i),
        .width_i        (width_i),
        .parity_i       (parity_i),
        .stop_i         (stop_i),
        .msb_first_i    (msb_first_i),
        .inv_line_i     (inv_line_i),
        .inv_data_i     (inv_data_i),
        .inv_line_act_o (inv_act),
        .reload_o       (reload),
        .reload_val_o   (reload_val),
        .halt_o         (halt),
        .ev_valid_o     (ev_valid_o),
        .ev_type_o      (ev_type_o),
        .ev_data_o      (ev_data_o)
    );

endmodule

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;

    localparam int DIV = 20;

    typedef struct packed {
        logic [3:0] w;
        logic [2:0] par;
        logic [1:0] stp;
        logic       msb;
        logic       invl;
        logic       invd;
        logic [8:0] d;
        logic       bad_par;
        logic       bad_stop;
    } vec_t;

    // Stimulus table: width, parity, stop, msb, invl, invd, data, bad parity, bad stop
    localparam vec_t VEC [10] = '{
        '{4'd8, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0}, // R3 plain
        '{4'd8, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0}, // R4 even
        '{4'd7, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0}, // R4 odd
        '{4'd5, 3'd3, 2'd1, 1'b1, 1'b0, 1'b0, 9'h013, 1'b0, 1'b0}, // R5 mark, R7 two stops, R3 msb
        '{4'd9, 3'd4, 2'd2, 1'b0, 1'b0, 1'b0, 9'h1A7, 1'b0, 1'b0}, // R5 space, R7 1.5 stop
        '{4'd6, 3'd2, 2'd3, 1'b1, 1'b1, 1'b0, 9'h02D, 1'b0, 1'b0}, // R9 line inversion, R7 half stop
        '{4'd8, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 9'h081, 1'b0, 1'b0}, // R10 data inversion
        '{4'd8, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 9'h007, 1'b1, 1'b0}, // R6 even mismatch
        '{4'd9, 3'd3, 2'd0, 1'b1, 1'b1, 1'b1, 9'h0F0, 1'b1, 1'b0}, // R6 mark mismatch, R9, R10
        '{4'd8, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b1}  // R8 bad stop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic [15:0] div = 16'(DIV);
    logic [3:0]  width = 4'd8;
    logic [2:0]  par = 3'd0;
    logic [1:0]  stp = 2'd0;
    logic        msb = 1'b0, invl = 1'b0, invd = 1'b0;
    logic        ev_valid;
    logic [2:0]  ev_type;
    logic [8:0]  ev_data;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    logic [2:0] cap_t [512];
    logic [8:0] cap_d [512];
    int cap_n = 0, base = 0;
    int exp_t [32];
    int exp_d [32];
    int exp_n = 0;

    always #10 clk = ~clk;

    serial_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line), .div_i(div), .width_i(width),
        .parity_i(par), .stop_i(stp), .msb_first_i(msb), .inv_line_i(invl),
        .inv_data_i(invd), .ev_valid_o(ev_valid), .ev_type_o(ev_type), .ev_data_o(ev_data)
    );

    // Event capture away from the active edge.
    always @(negedge clk) begin
        if (rst_n && ev_valid && cap_n < 512) begin
            cap_t[cap_n] = ev_type;
            cap_d[cap_n] = ev_data;
            cap_n++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            finish_run();
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int t, int d);
        exp_t[exp_n] = t;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    function automatic logic exp_parity(vec_t v);
        int ones = 0;
        for (int i = 0; i < int'(v.w); i++) ones += int'(v.d[i]);
        case (v.par)
            3'd1: return (ones % 2) == 0;
            3'd2: return (ones % 2) == 1;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Expected events for one frame, built from the requirements.
    task automatic append_exp(vec_t v);
        logic e, p;
        e = exp_parity(v);
        p = e ^ v.bad_par;
        push(0, 0);
        push(1, int'(v.d & ((9'd1 << v.w) - 9'd1)));
        if (v.par != 3'd0) begin
            push(2, int'(p));
            if (p != e) push(6, int'({e, p}));
        end
        if (v.bad_stop) push(5, 0);
        else begin
            push(3, 1);
            if (v.stp == 2'd1) push(3, 1);
        end
    endtask

    task automatic apply_cfg(vec_t v);
        width = v.w; par = v.par; stp = v.stp; msb = v.msb; invl = v.invl; invd = v.invd;
        line = 1'b1 ^ v.invl;
    endtask

    // Drive one frame's bits on the wire, start through stop.
    task automatic send_raw(vec_t v);
        logic p;
        p = exp_parity(v) ^ v.bad_par;
        line = 1'b0 ^ v.invl;
        wait_cyc(DIV);
        for (int i = 0; i < int'(v.w); i++) begin
            line = (v.msb ? v.d[int'(v.w) - 1 - i] : v.d[i]) ^ v.invd ^ v.invl;
            wait_cyc(DIV);
        end
        if (v.par != 3'd0) begin
            line = p ^ v.invd ^ v.invl;
            wait_cyc(DIV);
        end
        if (v.bad_stop) begin
            line = 1'b0 ^ v.invl;
            wait_cyc(DIV);
            line = 1'b1 ^ v.invl;
        end else begin
            line = 1'b1 ^ v.invl;
            case (v.stp)
                2'd1: wait_cyc(2 * DIV);
                2'd2: wait_cyc(DIV + DIV / 2);
                2'd3: wait_cyc(DIV / 2);
                default: wait_cyc(DIV);
            endcase
        end
    endtask

    task automatic settle(vec_t v);
        apply_cfg(v);
        wait_cyc(3 * DIV);
        base = cap_n;
        exp_n = 0;
    endtask

    task automatic compare(string tag);
        check({tag, " event count"}, cap_n - base, exp_n);
        for (int i = 0; i < exp_n && i < cap_n - base; i++) begin
            check({tag, " event type"}, int'(cap_t[base + i]), exp_t[i]);
            check({tag, " event data"}, int'(cap_d[base + i]), exp_d[i]);
        end
    endtask

    function automatic string vec_tag(int i);
        case (i)
            0: return "R3 R12 plain frame";
            1: return "R4 even parity";
            2: return "R4 odd parity";
            3: return "R5 R7 R3 mark two-stop msb";
            4: return "R5 R7 space 1.5-stop";
            5: return "R9 R7 line inversion half-stop";
            6: return "R10 data inversion";
            7: return "R6 parity mismatch";
            8: return "R6 R9 R10 mark mismatch inverted";
            default: return "R8 invalid stop";
        endcase
    endfunction

    initial begin
        // R1: reset state and no spurious events.
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2 * DIV);
        check("R1 no events after reset", cap_n, 0);
        check("R1 valid low after reset", int'(ev_valid), 0);

        // Table of frames.
        for (int i = 0; i < 10; i++) begin
            settle(VEC[i]);
            append_exp(VEC[i]);
            send_raw(VEC[i]);
            wait_cyc(2 * DIV);
            compare(vec_tag(i));
        end

        // R2: glitch shorter than half a bit.
        settle(VEC[0]);
        line = 1'b0;
        wait_cyc(4);
        line = 1'b1;
        wait_cyc(2 * DIV);
        push(4, 1);
        compare("R2 glitch start");

        // R7: back-to-back frames with half-period stop and no gap.
        settle(VEC[5]);
        append_exp(VEC[5]);
        append_exp(VEC[5]);
        send_raw(VEC[5]);
        send_raw(VEC[5]);
        wait_cyc(2 * DIV);
        compare("R7 back-to-back half stop");

        // R11: inputs changed mid-frame are ignored.
        settle(VEC[1]);
        append_exp(VEC[1]);
        fork
            send_raw(VEC[1]);
            begin
                wait_cyc(DIV);
                width = 4'd5; par = 3'd4; stp = 2'd1; msb = 1'b1; invd = 1'b1; div = 16'd8;
            end
        join
        wait_cyc(2 * DIV);
        compare("R11 config held during frame");
        div = 16'(DIV);

        // R3: width code above 9 acts as 9.
        begin
            vec_t v;
            v = VEC[4];
            settle(v);
            width = 4'd15;
            append_exp(v);
            send_raw(v);
            wait_cyc(2 * DIV);
            compare("R3 width clamp");
        end

        finish_run();
    end

endmodule